// File: doc/BRIEF.md
# Nibble-Sequenced Square and Cube Unit

This block evaluates one of several power and product expressions of an 8-bit unsigned operand, chosen by an 8-bit command code. The operand is latched when a start strobe is accepted and split into an upper nibble H and a lower nibble L. Every multiplication goes through one shared 4x4 multiplier. A small step program chooses what goes into the multiplier, where the product is placed, and which weight it gets.

A step program runs for each command. In each clock cycle one step picks two multiplier inputs. The first input is H, L, or one nibble of a nibble square kept from an earlier step; the second is H or L. The step then scales the 8-bit product by 1, 2 or 3 using shifts and adds, moves it by a whole number of nibble positions, and adds it into a 24-bit accumulator. The full square is built from three such terms. The full cube takes ten steps: it forms H² and L² first and then multiplies their nibbles by H or L.

The result and a one-cycle done pulse appear a fixed number of cycles after the start, and that number depends on the command. The result then holds until the next operation finishes. While an operation is running, the unit ignores any new start request.

Top module: `nib_pow_unit`

## Requirements
- R1: The operand is sampled only in the cycle in which a start is accepted. H is operand bits [7:4] and L is bits [3:0]. Changes to the operand or command inputs after that cycle do not affect the operation.
- R2: Code 8'h10 gives H·L, code 8'h1A gives H², and code 8'h3A gives L². Done is high in the 2nd cycle after the start cycle.
- R3: Code 8'h00 gives H²·L, code 8'h20 gives H³, code 8'h2A gives L³, and code 8'h4A gives H·L². Done is high in the 4th cycle after the start cycle.
- R4: Code 8'h5A gives the sum H+L, a value of up to 5 bits. Done is high in the 2nd cycle after the start cycle.
- R5: Code 8'hAA gives the square of the whole 8-bit operand. Done is high in the 4th cycle after the start cycle.
- R6: Code 8'hFF gives the cube of the whole 8-bit operand. Done is high in the 11th cycle after the start cycle.
- R7: Any other code gives a result of 0. Done is high in the 2nd cycle after the start cycle.
- R8: All results are unsigned and zero-extended to 24 bits. Done stays high for exactly one cycle per accepted start.
- R9: The result changes only in the cycle in which done is high. A start raised while an operation is running has no effect on the result, on the done timing, or on later done pulses.
- R10: A low level on the synchronous reset clears the result to 0 and done to 0 and abandons any operation in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Starts an operation when the unit is idle |
| cmd | input | 8 | Command code that selects the operation |
| operand | input | 8 | Unsigned operand, sampled with start |
| result | output | 24 | Result of the last completed operation |
| done | output | 1 | One-cycle pulse when the result is updated |

## Verification
The hardest case to reach is the cube. Its result is correct only if the kept H² is replaced by L² halfway through the program, and only if every nibble of both squares is weighted with the correct factor of 3 and the correct position. An error in the high product nibble shows up only for operands whose squares carry into the upper nibble. The stimulus therefore sweeps all 256 operands under every command, including one undefined code, and drives changed operand and command values after each start. Directed sequences cover a start raised halfway through a cube run and a reset applied in the middle of a cube.

// File: rtl/nib_pow_pkg.sv
// nib_pow_pkg: shared types, command decode and the per-command step program
// for the nibble square/cube unit. Assumes 8-bit command codes; the program is
// expressed in nibble units, so it is independent of the nibble width.
package nib_pow_pkg;

    localparam int CMD_W   = 8;
    localparam int IDX_W   = 4;
    localparam int POS_W   = 3;

    typedef enum logic [3:0] {
        OP_BAD, OP_H2L, OP_HL, OP_H3, OP_H2, OP_L3,
        OP_L2, OP_HL2, OP_SUM, OP_SQ, OP_CU
    } op_e;

    typedef enum logic [1:0] {
        SRC_H, SRC_L, SRC_SQ_HI, SRC_SQ_LO
    } src_e;

    typedef struct packed {
        src_e             a_src;    // first multiplier input
        logic             b_low;    // second input: 1 = L, 0 = H
        logic             keep_sq;  // store the product as the kept square
        logic             acc_en;   // add the weighted product
        logic             add_sum;  // add H+L instead of a product
        logic [1:0]       mult;     // weight 0..3
        logic [POS_W-1:0] pos;      // placement in nibble positions
        logic             last;     // final step of the program
    } step_t;

    function automatic op_e cmd_to_op(input logic [CMD_W-1:0] c);
        op_e o;
        case (c)
            8'h00:   o = OP_H2L;
            8'h10:   o = OP_HL;
            8'h20:   o = OP_H3;
            8'h1A:   o = OP_H2;
            8'h2A:   o = OP_L3;
            8'h3A:   o = OP_L2;
            8'h4A:   o = OP_HL2;
            8'h5A:   o = OP_SUM;
            8'hAA:   o = OP_SQ;
            8'hFF:   o = OP_CU;
            default: o = OP_BAD;
        endcase
        return o;
    endfunction

    function automatic step_t mk(input src_e a, input logic bl, input logic ks,
                                 input logic ae, input logic [1:0] m,
                                 input logic [POS_W-1:0] p, input logic l);
        step_t s;
        s.a_src   = a;
        s.b_low   = bl;
        s.keep_sq = ks;
        s.acc_en  = ae;
        s.add_sum = 1'b0;
        s.mult    = m;
        s.pos     = p;
        s.last    = l;
        return s;
    endfunction

    // Step table: one entry per (operation, step index)
    function automatic step_t prog_step(input op_e op, input logic [IDX_W-1:0] idx);
        step_t s;
        s = mk(SRC_H, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 1'b1);
        case (op)
            OP_HL:  s = mk(SRC_H, 1'b1, 1'b0, 1'b1, 2'd1, 3'd0, 1'b1);
            OP_H2:  s = mk(SRC_H, 1'b0, 1'b0, 1'b1, 2'd1, 3'd0, 1'b1);
            OP_L2:  s = mk(SRC_L, 1'b1, 1'b0, 1'b1, 2'd1, 3'd0, 1'b1);
            OP_SUM: s.add_sum = 1'b1;
            OP_H2L, OP_H3: begin
                case (idx)
                    4'd0:    s = mk(SRC_H,     1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 1'b0);
                    4'd1:    s = mk(SRC_SQ_HI, op == OP_H2L, 1'b0, 1'b1, 2'd1, 3'd1, 1'b0);
                    default: s = mk(SRC_SQ_LO, op == OP_H2L, 1'b0, 1'b1, 2'd1, 3'd0, 1'b1);
                endcase
            end
            OP_L3, OP_HL2: begin
                case (idx)
                    4'd0:    s = mk(SRC_L,     1'b1, 1'b1, 1'b0, 2'd0, 3'd0, 1'b0);
                    4'd1:    s = mk(SRC_SQ_HI, op == OP_L3, 1'b0, 1'b1, 2'd1, 3'd1, 1'b0);
                    default: s = mk(SRC_SQ_LO, op == OP_L3, 1'b0, 1'b1, 2'd1, 3'd0, 1'b1);
                endcase
            end
            OP_SQ: begin
                case (idx)
                    4'd0:    s = mk(SRC_H, 1'b0, 1'b0, 1'b1, 2'd1, 3'd2, 1'b0);
                    4'd1:    s = mk(SRC_H, 1'b1, 1'b0, 1'b1, 2'd2, 3'd1, 1'b0);
                    default: s = mk(SRC_L, 1'b1, 1'b0, 1'b1, 2'd1, 3'd0, 1'b1);
                endcase
            end
            OP_CU: begin
                case (idx)
                    4'd0:    s = mk(SRC_H,     1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 1'b0);
                    4'd1:    s = mk(SRC_SQ_HI, 1'b0, 1'b0, 1'b1, 2'd1, 3'd4, 1'b0);
                    4'd2:    s = mk(SRC_SQ_LO, 1'b0, 1'b0, 1'b1, 2'd1, 3'd3, 1'b0);
                    4'd3:    s = mk(SRC_SQ_HI, 1'b1, 1'b0, 1'b1, 2'd3, 3'd3, 1'b0);
                    4'd4:    s = mk(SRC_SQ_LO, 1'b1, 1'b0, 1'b1, 2'd3, 3'd2, 1'b0);
                    4'd5:    s = mk(SRC_L,     1'b1, 1'b1, 1'b0, 2'd0, 3'd0, 1'b0);
                    4'd6:    s = mk(SRC_SQ_HI, 1'b0, 1'b0, 1'b1, 2'd3, 3'd2, 1'b0);
                    4'd7:    s = mk(SRC_SQ_LO, 1'b0, 1'b0, 1'b1, 2'd3, 3'd1, 1'b0);
                    4'd8:    s = mk(SRC_SQ_HI, 1'b1, 1'b0, 1'b1, 2'd1, 3'd1, 1'b0);
                    default: s = mk(SRC_SQ_LO, 1'b1, 1'b0, 1'b1, 2'd1, 3'd0, 1'b1);
                endcase
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/nib_pow_mul.sv
// nib_pow_mul: unsigned W x W array multiplier, combinational.
// Assumes both inputs are unsigned; product is 2*W bits.
module nib_pow_mul #(
    parameter int W = 4
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    logic [2*W-1:0] row [W];

    // One shifted copy of a per set bit of b
    for (genvar i = 0; i < W; i++) begin : g_row
        assign row[i] = b[i] ? ({{W{1'b0}}, a} << i) : '0;
    end

    // Sum the rows
    always_comb begin
        p = '0;
        for (int i = 0; i < W; i++) begin
            p = p + row[i];
        end
    end
endmodule

// File: rtl/nib_pow_seq.sv
// nib_pow_seq: accepts a start when idle, latches operand and decoded command,
// and walks the step program one step per cycle until the last step.
// Assumes start is ignored while busy.
module nib_pow_seq
    import nib_pow_pkg::*;
#(
    parameter int NIB_W  = 4,
    parameter int OPND_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [OPND_W-1:0] operand,
    output logic              busy,
    output logic              load,
    output logic [OPND_W-1:0] opnd_q,
    output step_t             step
);
    op_e              op_q;
    logic [IDX_W-1:0] idx_q;

    assign load = start && !busy;

    // Current step from the program table
    always_comb step = prog_step(op_q, idx_q);

    // Sequencing state: capture on accepted start, advance while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            idx_q  <= '0;
            op_q   <= OP_BAD;
            opnd_q <= '0;
        end else if (load) begin
            busy   <= 1'b1;
            idx_q  <= '0;
            op_q   <= cmd_to_op(cmd);
            opnd_q <= operand;
        end else if (busy) begin
            if (step.last) begin
                busy <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/nib_pow_acc.sv
// nib_pow_acc: operand multiplexers, shared multiplier, weight/shift logic
// and the accumulator plus kept-square register. Assumes clear arrives in the
// cycle a start is accepted, so the accumulator is zero at step 0.
module nib_pow_acc
    import nib_pow_pkg::*;
#(
    parameter int NIB_W = 4,
    parameter int RES_W = 6 * NIB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             valid,
    input  step_t            step,
    input  logic [NIB_W-1:0] hi,
    input  logic [NIB_W-1:0] lo,
    output logic [RES_W-1:0] acc_next,
    output logic             finish
);
    localparam int PW = 2 * NIB_W;

    logic [NIB_W-1:0] a_op, b_op;
    logic [PW-1:0]    prod, sq_q;
    logic [PW+1:0]    scaled;
    logic [RES_W-1:0] term, acc_q;
    int unsigned      sh;

    // First multiplier input select
    always_comb begin
        case (step.a_src)
            SRC_H:     a_op = hi;
            SRC_L:     a_op = lo;
            SRC_SQ_HI: a_op = sq_q[PW-1:NIB_W];
            default:   a_op = sq_q[NIB_W-1:0];
        endcase
    end

    assign b_op = step.b_low ? lo : hi;

    nib_pow_mul #(.W(NIB_W)) u_mul (.a(a_op), .b(b_op), .p(prod));

    // Weight by 0..3 using shift and add only
    always_comb begin
        case (step.mult)
            2'd1:    scaled = {2'b00, prod};
            2'd2:    scaled = {1'b0, prod, 1'b0};
            2'd3:    scaled = {1'b0, prod, 1'b0} + {2'b00, prod};
            default: scaled = '0;
        endcase
    end

    // Term placement and accumulator next value
    always_comb begin
        sh = int'(step.pos) * NIB_W;
        if (step.add_sum) begin
            term = RES_W'({1'b0, hi} + {1'b0, lo});
        end else if (step.acc_en) begin
            term = RES_W'(scaled) << sh;
        end else begin
            term = '0;
        end
        acc_next = acc_q + term;
    end

    assign finish = valid && step.last;

    // Accumulator and kept-square registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            sq_q  <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else if (valid) begin
            acc_q <= acc_next;
            if (step.keep_sq) begin
                sq_q <= prod;
            end
        end
    end
endmodule

// File: rtl/nib_pow_unit.sv
// nib_pow_unit: top of the command-driven nibble square/cube unit.
// Assumes unsigned operands and one operation in flight at a time.
module nib_pow_unit
    import nib_pow_pkg::*;
#(
    parameter  int NIB_W  = 4,
    localparam int OPND_W = 2 * NIB_W,
    localparam int RES_W  = 3 * OPND_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [OPND_W-1:0] operand,
    output logic [RES_W-1:0]  result,
    output logic              done
);
    logic              busy, load, finish;
    logic [OPND_W-1:0] opnd_q;
    step_t             step;
    logic [RES_W-1:0]  acc_next;

    nib_pow_seq #(.NIB_W(NIB_W), .OPND_W(OPND_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .operand(operand),
        .busy(busy), .load(load), .opnd_q(opnd_q), .step(step)
    );

    nib_pow_acc #(.NIB_W(NIB_W), .RES_W(RES_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(load), .valid(busy), .step(step),
        .hi(opnd_q[OPND_W-1:NIB_W]), .lo(opnd_q[NIB_W-1:0]),
        .acc_next(acc_next), .finish(finish)
    );

    // Result register and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                result <= acc_next;
            end
        end
    end
endmodule

// File: rtl/nib_pow_chk.sv
// nib_pow_chk: temporal properties of nib_pow_unit, bound to every instance.
module nib_pow_chk #(
    parameter  int NIB_W  = 4,
    localparam int OPND_W = 2 * NIB_W,
    localparam int RES_W  = 3 * OPND_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [7:0]        cmd,
    input logic [OPND_W-1:0] operand,
    input logic [RES_W-1:0]  result,
    input logic              done,
    input logic              busy,
    input logic [OPND_W-1:0] opnd_q
);
    function automatic logic [RES_W-1:0] sq_of(input logic [OPND_W-1:0] x);
        logic [RES_W-1:0] e;
        e = RES_W'(x);
        return e * e;
    endfunction

    function automatic logic [RES_W-1:0] cu_of(input logic [OPND_W-1:0] x);
        logic [RES_W-1:0] e;
        e = RES_W'(x);
        return e * e * e;
    endfunction

    function automatic logic known(input logic [7:0] c);
        return c == 8'h00 || c == 8'h10 || c == 8'h20 || c == 8'h1A ||
               c == 8'h2A || c == 8'h3A || c == 8'h4A || c == 8'h5A ||
               c == 8'hAA || c == 8'hFF;
    endfunction

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(opnd_q));

    p_bad_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !known(cmd)) |=> ##1 (done && result == '0));

    p_square_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cmd == 8'hAA) |=> ##3 (done && result == sq_of($past(operand, 4))));

    p_cube_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cmd == 8'hFF) |=> ##10 (done && result == cu_of($past(operand, 11))));
endmodule

bind nib_pow_unit nib_pow_chk #(.NIB_W(NIB_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .operand(operand),
    .result(result), .done(done), .busy(busy), .opnd_q(opnd_q)
);

// File: tb/nib_pow_unit_bench.sv
// nib_pow_unit_bench: vector table, full operand sweep per command, and
// directed reset / busy-start cases.
module nib_pow_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  cmd = 8'h00;
    logic [7:0]  operand = 8'h00;
    logic [23:0] result;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    nib_pow_unit u_nib_pow_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
        .operand(operand), .result(result), .done(done)
    );

    localparam logic [39:0] VEC [14] = '{
        {8'hFF, 8'hFF, 24'd16581375},
        {8'hAA, 8'hFF, 24'd65025},
        {8'h00, 8'hF3, 24'd675},
        {8'h10, 8'hF3, 24'd45},
        {8'h20, 8'hF3, 24'd3375},
        {8'h1A, 8'h7B, 24'd49},
        {8'h2A, 8'h7B, 24'd1331},
        {8'h3A, 8'h7B, 24'd121},
        {8'h4A, 8'h7B, 24'd847},
        {8'h5A, 8'hFF, 24'd30},
        {8'hAA, 8'hA5, 24'd27225},
        {8'hFF, 8'h02, 24'd8},
        {8'h37, 8'hFF, 24'd0},
        {8'h4A, 8'hFF, 24'd3375}
    };

    localparam logic [7:0] CMDS [11] = '{
        8'h00, 8'h10, 8'h20, 8'h1A, 8'h2A, 8'h3A, 8'h4A, 8'h5A, 8'hAA, 8'hFF, 8'h5B
    };

    function automatic logic [23:0] model(input logic [7:0] c, input logic [7:0] x);
        logic [23:0] h, l, v;
        h = 24'(x[7:4]);
        l = 24'(x[3:0]);
        v = 24'(x);
        case (c)
            8'h00:   return h * h * l;
            8'h10:   return h * l;
            8'h20:   return h * h * h;
            8'h1A:   return h * h;
            8'h2A:   return l * l * l;
            8'h3A:   return l * l;
            8'h4A:   return h * l * l;
            8'h5A:   return h + l;
            8'hAA:   return v * v;
            8'hFF:   return v * v * v;
            default: return 24'd0;
        endcase
    endfunction

    function automatic int lat_of(input logic [7:0] c);
        case (c)
            8'h00, 8'h20, 8'h2A, 8'h4A, 8'hAA: return 4;
            8'hFF:                             return 11;
            default:                           return 2;
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] c);
        case (c)
            8'h10, 8'h1A, 8'h3A:        return "R2";
            8'h00, 8'h20, 8'h2A, 8'h4A: return "R3";
            8'h5A:                      return "R4";
            8'hAA:                      return "R5";
            8'hFF:                      return "R6";
            default:                    return "R7";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Issue one op, scramble inputs after the start cycle (R1), measure latency
    task automatic run_op(input logic [7:0] c, input logic [7:0] x);
        int cnt;
        logic [23:0] exp_v;
        @(negedge clk);
        start = 1'b1; cmd = c; operand = x;
        @(negedge clk);
        start = 1'b0; cmd = ~c; operand = ~x;
        cnt = 1;
        while (!done && cnt < 40) begin
            @(negedge clk);
            cnt++;
        end
        exp_v = model(c, x);
        chk(result == exp_v, req_of(c), $sformatf("cmd %h opnd %h result (R1, R8)", c, x), result, exp_v);
        chk(cnt == lat_of(c), req_of(c), $sformatf("cmd %h latency", c), 24'(cnt), 24'(lat_of(c)));
        @(negedge clk);
        chk(!done, "R8", "done longer than one cycle", 24'(done), 24'd0);
        chk(result == exp_v, "R9", "result not held after done", result, exp_v);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R8 watchdog: actual=hung expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(result == 24'd0, "R10", "reset result", result, 24'd0);
        chk(!done, "R10", "reset done", 24'(done), 24'd0);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < 14; i++) begin
            run_op(VEC[i][39:32], VEC[i][31:24]);
            chk(result == VEC[i][23:0], req_of(VEC[i][39:32]), "table vector", result, VEC[i][23:0]);
        end

        // Full sweep: every command, every operand
        for (int c = 0; c < 11; c++) begin
            for (int x = 0; x < 256; x++) begin
                run_op(CMDS[c], 8'(x));
            end
        end

        // R9: start raised while a cube is running
        @(negedge clk);
        start = 1'b1; cmd = 8'hFF; operand = 8'h02;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1; cmd = 8'hAA; operand = 8'hFF;
        @(negedge clk);
        start = 1'b0;
        begin
            int cnt;
            cnt = 3;
            while (!done && cnt < 40) begin
                @(negedge clk);
                cnt++;
            end
            chk(cnt == 11, "R9", "cube latency with busy start", 24'(cnt), 24'd11);
            chk(result == 24'd8, "R9", "cube result with busy start", result, 24'd8);
        end
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(!done, "R9", "extra done from ignored start", 24'(done), 24'd0);
            chk(result == 24'd8, "R9", "result changed by ignored start", result, 24'd8);
        end

        // R10: reset in the middle of a cube
        @(negedge clk);
        start = 1'b1; cmd = 8'hFF; operand = 8'hFF;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(result == 24'd0, "R10", "mid-op reset result", result, 24'd0);
        chk(!done, "R10", "mid-op reset done", 24'(done), 24'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk(!done, "R10", "abandoned op completed", 24'(done), 24'd0);
        end
        chk(result == 24'd0, "R10", "result after abandoned op", result, 24'd0);

        // Unit still works after reset
        run_op(8'hFF, 8'h13);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule